// File: doc/BRIEF.md
# Secured configuration fuse memory

This block stores the configuration bit pattern of a programmable logic array and drives every stored bit to that array at all times. A command port with a valid/ready handshake lets a programmer write whole words or single bits, read words back for verification, lock the pattern against readback, and erase it in bulk. Cells read as 0 when erased and as 1 when programmed. A programming step can only change a cell from 0 to 1. Only an erase returns a cell to 0.

Programming is grouped into sessions. The first program command after any other command opens a new session. Before it writes, it erases the whole array. That erase also removes the security lock. Later program commands in the same session write at once. Once the lock is set, verify reads return all ones, but the array still receives the real pattern. The lock cannot be cleared by itself. Only an erase of the whole pattern clears it, whether that erase is commanded directly or starts a new session.

Top module: `fuse_cfg_mem`

## Requirements
- R1: After synchronous reset every stored cell is 0, `secured` is 0, `cmd_ready` is 1, `busy` is 0 and `rd_valid` is 0.
- R2: Within an open session, a program-word command (op 1) ORs `cmd_wdata` into the word at `cmd_addr`, so bits that are already set stay set.
- R3: A program command (op 1 or 2) that opens a session first clears all N_WORDS words and the lock, then writes. `cmd_ready` stays low for N_WORDS+1 cycles after the command is accepted.
- R4: A program-bit command (op 2) sets only bit `cmd_bit` of the word at `cmd_addr`.
- R5: A verify command (op 3) raises `rd_valid` for one cycle, in the cycle after it is accepted. While unlocked, `rd_data` then carries the stored word.
- R6: A secure command (op 4) sets `secured`. Every later verify returns all ones until the lock is cleared.
- R7: A clear-lock command (op 6) is accepted but refused: `secured` stays 1 and readback stays all ones.
- R8: `cfg_bits` always shows the stored pattern, even while locked. Word i sits at bits [i*WORD_W +: WORD_W].
- R9: An erase command (op 5) clears every word and the lock within N_WORDS cycles. After that, readback returns zeros.
- R10: Within an open session, a program command performs no erase. `cmd_ready` stays low for exactly 1 cycle.
- R11: Any accepted command other than op 1 or 2 closes the session. Opcodes 0 and 7 change no stored bit and no lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (controller idle) |
| cmd_op | input | 3 | Opcode: 1 prog word, 2 prog bit, 3 verify, 4 secure, 5 erase, 6 clear lock, 0/7 no-op |
| cmd_addr | input | ADDR_W | Word address |
| cmd_bit | input | BIT_W | Bit index for program-bit |
| cmd_wdata | input | WORD_W | Data for program-word |
| rd_valid | output | 1 | Readback strobe |
| rd_data | output | WORD_W | Readback word |
| busy | output | 1 | An erase or write is in progress |
| secured | output | 1 | Readback lock is set |
| cfg_bits | output | N_WORDS*WORD_W | Stored pattern fed to the logic array |

## Verification
Random word patterns are programmed and then read back. This shows the difference between a correct store and a stuck or misaddressed word. Writing twice into the same word tells OR-programming apart from overwriting. A second session started over an existing pattern shows whether the automatic erase really happens. Sessions closed by no-op, verify and refused clear-lock commands show that these commands end a session without changing any data. With the lock set, all-ones readback is compared with the still-real `cfg_bits`. A further program command over the lock shows that only an erase removes it.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_PROG_WORD = 3'd1,
        OP_PROG_BIT  = 3'd2,
        OP_VERIFY    = 3'd3,
        OP_SECURE    = 3'd4,
        OP_ERASE     = 3'd5,
        OP_UNLOCK    = 3'd6,
        OP_RSVD      = 3'd7
    } fuse_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_WRITE = 2'd2
    } ctrl_state_e;

    function automatic logic is_prog(input logic [2:0] op);
        return (op == OP_PROG_WORD) || (op == OP_PROG_BIT);
    endfunction
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
    parameter int WORD_W  = 8,
    parameter int N_WORDS = 16,
    parameter int ADDR_W  = $clog2(N_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_en,
    input  logic [ADDR_W-1:0]           clr_addr,
    input  logic                        set_en,
    input  logic [ADDR_W-1:0]           set_addr,
    input  logic [WORD_W-1:0]           set_mask,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [WORD_W-1:0]           rd_word,
    output logic [N_WORDS*WORD_W-1:0]   cfg_bits
);
    logic [WORD_W-1:0] cells [N_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_WORDS; i++) cells[i] <= '0;
        end else begin
            if (clr_en) cells[clr_addr] <= '0;
            if (set_en) cells[set_addr] <= cells[set_addr] | set_mask;
        end
    end

    assign rd_word = cells[rd_addr];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_cfg
        assign cfg_bits[g*WORD_W +: WORD_W] = cells[g];
    end

    // Checker: a cleared word reads blank on the following cycle (R9)
    logic              clr_q;
    logic [ADDR_W-1:0] clr_addr_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q      <= 1'b0;
            clr_addr_q <= '0;
        end else begin
            clr_q      <= clr_en;
            clr_addr_q <= clr_addr;
            if (clr_q) begin
                p_clear_blank_r9: assert (cells[clr_addr_q] == '0)
                    else $error("cleared word not blank");
            end
        end
    end

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_en && !set_en) |=> $stable(cfg_bits));
endmodule

// File: rtl/fuse_readgate.sv
module fuse_readgate #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              lock,
    input  logic [WORD_W-1:0] raw_word,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= lock ? '1 : raw_word;
        end
    end

    p_secured_ones_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(lock)) |-> (rd_data == '1));

    p_read_latency_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
    import fuse_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int N_WORDS = 16,
    parameter int ADDR_W  = $clog2(N_WORDS),
    parameter int BIT_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BIT_W-1:0]  cmd_bit,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              busy,
    output logic              lock,
    output logic              clr_en,
    output logic [ADDR_W-1:0] clr_addr,
    output logic              set_en,
    output logic [ADDR_W-1:0] set_addr,
    output logic [WORD_W-1:0] set_mask,
    output logic              rd_req
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_WORDS - 1);

    ctrl_state_e       state;
    logic [ADDR_W-1:0] sweep;
    logic              session_q;
    logic              lock_q;
    logic              pend_write;
    logic [ADDR_W-1:0] pend_addr;
    logic [WORD_W-1:0] pend_mask;
    logic              accept;
    logic [WORD_W-1:0] cmd_mask;

    assign accept    = cmd_valid && (state == ST_IDLE);
    assign cmd_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign lock      = lock_q;
    assign rd_req    = accept && (cmd_op == OP_VERIFY);
    assign clr_en    = (state == ST_ERASE);
    assign clr_addr  = sweep;
    assign set_en    = (state == ST_WRITE);
    assign set_addr  = pend_addr;
    assign set_mask  = pend_mask;

    always_comb begin
        if (cmd_op == OP_PROG_BIT) cmd_mask = WORD_W'(1) << cmd_bit;
        else                       cmd_mask = cmd_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sweep      <= '0;
            session_q  <= 1'b0;
            lock_q     <= 1'b0;
            pend_write <= 1'b0;
            pend_addr  <= '0;
            pend_mask  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    if (is_prog(cmd_op)) begin
                        pend_addr <= cmd_addr;
                        pend_mask <= cmd_mask;
                        session_q <= 1'b1;
                        if (session_q) begin
                            state <= ST_WRITE;
                        end else begin
                            state      <= ST_ERASE;
                            sweep      <= '0;
                            pend_write <= 1'b1;
                        end
                    end else begin
                        session_q <= 1'b0;
                        if (cmd_op == OP_SECURE) lock_q <= 1'b1;
                        if (cmd_op == OP_ERASE) begin
                            state      <= ST_ERASE;
                            sweep      <= '0;
                            pend_write <= 1'b0;
                        end
                    end
                end
                ST_ERASE: begin
                    sweep <= sweep + 1'b1;
                    if (sweep == LAST_ADDR) begin
                        lock_q <= 1'b0;
                        sweep  <= '0;
                        state  <= pend_write ? ST_WRITE : ST_IDLE;
                    end
                end
                ST_WRITE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (lock_q && state != ST_ERASE) |=> lock_q);

    p_unlock_by_erase_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> ($past(state) == ST_ERASE));

    p_new_session_erases_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && is_prog(cmd_op) && !session_q) |=> (state == ST_ERASE));

    p_session_no_erase_r10: assert property (@(posedge clk) disable iff (rst)
        (accept && is_prog(cmd_op) && session_q) |=> (state == ST_WRITE));
endmodule

// File: rtl/fuse_cfg_mem.sv
module fuse_cfg_mem #(
    parameter int WORD_W  = 8,
    parameter int N_WORDS = 16,
    parameter int ADDR_W  = $clog2(N_WORDS),
    parameter int BIT_W   = $clog2(WORD_W)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic [2:0]                cmd_op,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic [BIT_W-1:0]          cmd_bit,
    input  logic [WORD_W-1:0]         cmd_wdata,
    output logic                      rd_valid,
    output logic [WORD_W-1:0]         rd_data,
    output logic                      busy,
    output logic                      secured,
    output logic [N_WORDS*WORD_W-1:0] cfg_bits
);
    logic              clr_en, set_en, rd_req, lock;
    logic [ADDR_W-1:0] clr_addr, set_addr;
    logic [WORD_W-1:0] set_mask, raw_word;

    fuse_ctrl #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bit(cmd_bit), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .busy(busy), .lock(lock),
        .clr_en(clr_en), .clr_addr(clr_addr), .set_en(set_en),
        .set_addr(set_addr), .set_mask(set_mask), .rd_req(rd_req)
    );

    fuse_array #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .clr_en(clr_en), .clr_addr(clr_addr),
        .set_en(set_en), .set_addr(set_addr), .set_mask(set_mask),
        .rd_addr(cmd_addr), .rd_word(raw_word), .cfg_bits(cfg_bits)
    );

    fuse_readgate #(.WORD_W(WORD_W)) u_rgate (
        .clk(clk), .rst(rst), .rd_req(rd_req), .lock(lock),
        .raw_word(raw_word), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign secured = lock;
endmodule

// File: tb/tb_fuse_cfg_mem.sv
module tb_fuse_cfg_mem;
    localparam int W  = 8;
    localparam int N  = 16;
    localparam int AW = $clog2(N);
    localparam int BW = $clog2(W);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [2:0]      cmd_op = '0;
    logic [AW-1:0]   cmd_addr = '0;
    logic [BW-1:0]   cmd_bit = '0;
    logic [W-1:0]    cmd_wdata = '0;
    logic            rd_valid;
    logic [W-1:0]    rd_data;
    logic            busy;
    logic            secured;
    logic [N*W-1:0]  cfg_bits;

    fuse_cfg_mem #(.WORD_W(W), .N_WORDS(N)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bit(cmd_bit),
        .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .secured(secured), .cfg_bits(cfg_bits)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] model [N];
    bit           locked_m = 0;
    bit           sess_m   = 0;
    logic         last_rv;
    logic [W-1:0] last_rd;
    int           last_busy;

    function automatic logic [W-1:0] exp_rd(input int a);
        return locked_m ? {W{1'b1}} : model[a];
    endfunction

    function automatic logic [N*W-1:0] model_flat();
        logic [N*W-1:0] f;
        for (int i = 0; i < N; i++) f[i*W +: W] = model[i];
        return f;
    endfunction

    task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input int a, input int b, input logic [W-1:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_bit = BW'(b); cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        last_rv = rd_valid;
        last_rd = rd_data;
        last_busy = 0;
        while (!cmd_ready) begin
            last_busy++;
            @(negedge clk);
        end
    endtask

    task automatic prog(input logic [2:0] op, input int a, input int b, input logic [W-1:0] d);
        int exp_busy;
        if (!sess_m) begin
            for (int i = 0; i < N; i++) model[i] = '0;
            locked_m = 0;
            exp_busy = N + 1;
        end else begin
            exp_busy = 1;
        end
        issue(op, a, b, d);
        if (op == 3'd2) model[a][b] = 1'b1;
        else            model[a] = model[a] | d;
        check(sess_m ? "R10 busy in session" : "R3 busy with erase", last_busy, exp_busy);
        sess_m = 1;
    endtask

    task automatic other(input logic [2:0] op);
        issue(op, 0, 0, '0);
        sess_m = 0;
        if (op == 3'd4) locked_m = 1;
        if (op == 3'd5) begin
            for (int i = 0; i < N; i++) model[i] = '0;
            locked_m = 0;
        end
    endtask

    task automatic verify(input string req, input int a);
        issue(3'd3, a, 0, '0);
        sess_m = 0;
        check({req, " rd_valid"}, last_rv, 1'b1);
        check({req, " rd_data"}, last_rd, exp_rd(a));
    endtask

    initial begin
        int seed;
        logic [W-1:0] d;
        seed = $urandom(32'd424242);
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1 ready", cmd_ready, 1'b1);
        check("R1 busy", busy, 1'b0);
        check("R1 rd_valid", rd_valid, 1'b0);
        check("R1 secured", secured, 1'b0);
        check("R1 cfg", cfg_bits, '0);

        // R3 / R10 / R2: fill a random pattern in one session
        for (int i = 0; i < N; i++) begin
            d = W'($urandom);
            prog(3'd1, i, 0, d);
        end
        check("R2 cfg after fill", cfg_bits, model_flat());
        for (int i = 0; i < N; i++) verify("R5 verify fill", i);

        // R3: new session over an existing pattern erases it first
        prog(3'd1, 5, 0, 8'h3C);
        check("R3 only new word", cfg_bits, model_flat());
        prog(3'd1, 5, 0, 8'hC1);
        check("R2 OR merge", cfg_bits[5*W +: W], 8'hFD);
        prog(3'd2, 9, 6, '0);
        check("R4 single bit", cfg_bits[9*W +: W], 8'h40);
        for (int k = 0; k < 6; k++) begin
            int a = int'($urandom_range(N-1, 0));
            int b = int'($urandom_range(W-1, 0));
            prog(3'd2, a, b, '0);
        end
        check("R4 random bits", cfg_bits, model_flat());
        verify("R5 verify bits", 9);

        // R11: no-op opcodes leave data alone but close the session
        prog(3'd1, 2, 0, 8'h11);
        other(3'd0);
        check("R11 op0 no change", cfg_bits, model_flat());
        prog(3'd1, 3, 0, 8'h22);
        check("R11 session closed by op0", cfg_bits, model_flat());
        other(3'd7);
        check("R11 op7 no change", cfg_bits, model_flat());
        check("R11 op7 no lock", secured, 1'b0);

        // Load a random pattern, then lock
        for (int i = 0; i < N; i++) prog(3'd1, i, 0, W'($urandom));
        other(3'd4);
        check("R6 secured set", secured, 1'b1);
        for (int k = 0; k < 5; k++) verify("R6 locked readback", int'($urandom_range(N-1, 0)));
        check("R8 cfg real while locked", cfg_bits, model_flat());
        other(3'd6);
        check("R7 clear-lock refused", secured, 1'b1);
        verify("R7 still ones", 4);
        check("R8 cfg after refuse", cfg_bits, model_flat());

        // R9: explicit erase
        other(3'd5);
        check("R9 unlocked", secured, 1'b0);
        check("R9 blank cfg", cfg_bits, '0);
        for (int i = 0; i < N; i += 5) verify("R9 blank readback", i);

        // R3: a new session over a lock erases the lock too
        prog(3'd1, 0, 0, 8'h5A);
        other(3'd4);
        prog(3'd1, 7, 0, 8'hA5);
        check("R3 lock cleared by session erase", secured, 1'b0);
        check("R3 cfg after locked session", cfg_bits, model_flat());
        verify("R5 verify after relock", 7);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule